// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of an SDRAM read or write burst. A one-cycle start request captures an 8-bit starting column together with a 3-bit burst-length code and a one-bit burst-type select. One clock later the block begins to emit one column per clock. Each column comes with a valid flag, and a last-beat flag marks the final beat of a finite burst.

The burst stays inside the aligned block of columns whose size equals the burst length. The upper column bits hold the start value for the whole burst. The low bits either count upward and wrap at the block edge (sequential order) or follow the start value XOR the beat index (interleaved order). A full-page burst walks all 256 columns in sequential order and keeps going until a terminate input stops it. A small decoder checks the length and type fields. An illegal combination raises an error pulse and starts no burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `mode_err_o` are 0 and `col_o` is 0.
- R2: The length code `len_code_i` encodes 3'b001 = 2 beats, 3'b010 = 4 beats, 3'b011 = 8 beats and 3'b111 = full page (256 columns). `ilv_i` = 0 selects sequential order and 1 selects interleaved order. A start request made while idle with a legal setting makes `valid_o` high on the following clock, and `col_o` then equals the starting column.
- R3: In sequential order, with BL the burst length and S the start column, beat k has column (S with its low log2(BL) bits cleared) plus ((S + k) mod BL).
- R4: In interleaved order, beat k has column (S with its low log2(BL) bits cleared) plus ((S mod BL) XOR k).
- R5: During a burst, the column bits above the block size never change from beat to beat.
- R6: A finite burst gives exactly BL valid beats. `last_o` is high only on beat BL-1, and `valid_o` is low on the clock after it.
- R7: A full-page burst in sequential order produces S, S+1, … modulo 256 without end. It never raises `last_o`.
- R8: When `term_i` is high during a valid beat, `valid_o` is low on the next clock, whatever the burst length.
- R9: A start request with an unlisted length code (000, 100, 101, 110), or with full page combined with interleaved order, raises `mode_err_o` for exactly one clock on the following cycle and starts no burst.
- R10: A start request made while a burst is running is ignored. The running burst's columns and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Ends the running burst after the current beat |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat of a finite burst |
| mode_err_o | output | 1 | One-cycle pulse after an illegal start request |

## Verification
Three events can coincide in one cycle: the last beat, a terminate request, and a start request that arrives while the burst is still running. The bench drives `term_i` exactly on the last beat of some bursts and holds `start_i` high through the middle beats of others. In both cases it expects the burst to end exactly once, on its natural boundary or the terminate, and expects the ignored start to leave no trace in the columns. Random bursts with random start columns, lengths and orders are compared with columns that a bench function computes by plain addition and XOR.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int COL_W = 8;

  // Column of beat k: upper bits kept, low bits walk by add or XOR
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] scol,
    input logic [COL_W-1:0] beat,
    input logic [COL_W-1:0] mask,
    input logic             ilv
  );
    logic [COL_W-1:0] low;
    low = ilv ? (scol ^ beat) : (scol + beat);
    return (scol & ~mask) | (low & mask);
  endfunction
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_pkg::*;
(
  input  logic [2:0]       len_code,
  input  logic             ilv,
  output logic             legal,
  output logic             full,
  output logic [COL_W-1:0] mask
);
  always_comb begin
    legal = 1'b1;
    full  = 1'b0;
    mask  = '0;
    case (len_code)
      3'b001: mask = COL_W'(1);
      3'b010: mask = COL_W'(3);
      3'b011: mask = COL_W'(7);
      3'b111: begin
        mask  = '1;
        full  = 1'b1;
        legal = ~ilv;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             legal_in,
  input  logic             full_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             ilv_in,
  input  logic             term,
  output logic             busy,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] scol,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             last,
  output logic             err
);
  logic full;
  // named internal events
  logic accept_ev, reject_ev, finish_ev;

  assign accept_ev = start & ~busy & legal_in;
  assign reject_ev = start & ~busy & ~legal_in;
  assign last      = busy & ~full & (beat == mask);
  assign finish_ev = busy & (term | last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
      scol <= '0;
      mask <= '0;
      ilv  <= 1'b0;
      full <= 1'b0;
      err  <= 1'b0;
    end else begin
      err <= reject_ev;
      if (accept_ev) begin
        busy <= 1'b1;
        beat <= '0;
        scol <= start_col;
        mask <= mask_in;
        ilv  <= ilv_in;
        full <= full_in;
      end else if (finish_ev) begin
        busy <= 1'b0;
      end else if (busy) begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R6
  beat_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !full) |-> ((beat & ~mask) == '0));
  // R6
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
  // R8
  term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && term) |=> !busy);
  // R9
  err_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (err && !busy));
  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_ev) |=> ($stable(scol) && $stable(mask) && $stable(ilv)));
  // R7
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && full) |-> !last);
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_pkg::*;
(
  input  logic [COL_W-1:0] scol,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  assign col = beat_col(scol, beat, mask, ilv);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             mode_err_o
);
  logic             dec_legal, dec_full, q_ilv;
  logic [COL_W-1:0] dec_mask, q_beat, q_scol, q_mask;

  burst_mode_dec u_dec (
    .len_code (len_code_i),
    .ilv      (ilv_i),
    .legal    (dec_legal),
    .full     (dec_full),
    .mask     (dec_mask)
  );

  burst_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .start_col (start_col_i),
    .legal_in  (dec_legal),
    .full_in   (dec_full),
    .mask_in   (dec_mask),
    .ilv_in    (ilv_i),
    .term      (term_i),
    .busy      (valid_o),
    .beat      (q_beat),
    .scol      (q_scol),
    .mask      (q_mask),
    .ilv       (q_ilv),
    .last      (last_o),
    .err       (mode_err_o)
  );

  burst_col_map u_map (
    .scol (q_scol),
    .beat (q_beat),
    .mask (q_mask),
    .ilv  (q_ilv),
    .col  (col_o)
  );

  // R5
  upper_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> ((col_o | q_mask) == ($past(col_o) | q_mask)));
  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> !mode_err_o);
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, mode_err_o;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .mode_err_o(mode_err_o)
  );

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input int s, input int k, input int bl, input bit il);
    int base;
    base = s - (s % bl);
    if (il) return 8'(base + ((s % bl) ^ k));
    return 8'(base + ((s + k) % bl));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // term_at < 0: no terminate; poke: hold start high on middle beats
  task automatic run_burst(input int s, input logic [2:0] code, input bit il,
                           input int term_at, input bit poke);
    int bl, nb;
    string rq;
    bl = len_of(code);
    rq = (bl == 256) ? "R7" : (il ? "R4" : "R3");
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(s); len_code_i = code; ilv_i = il;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 8'(s), "R2", int'(col_o), s);
    nb = (term_at >= 0 && (bl == 256 || term_at < bl)) ? term_at + 1 : bl;
    for (int k = 0; k < nb; k++) begin
      chk(valid_o === 1'b1, "R6", int'(valid_o), 1);
      chk(col_o === exp_col(s, k, bl, il), rq, int'(col_o), int'(exp_col(s, k, bl, il)));
      chk(last_o === ((bl != 256) && k == bl - 1), (bl == 256) ? "R7" : "R6",
          int'(last_o), int'((bl != 256) && k == bl - 1));
      if (poke) begin
        start_i = (k < nb - 1); start_col_i = ~8'(s); len_code_i = 3'b001; ilv_i = ~il;
      end
      term_i = (k == term_at);
      @(negedge clk);
    end
    start_i = 1'b0; term_i = 1'b0;
    chk(valid_o === 1'b0, (term_at >= 0) ? "R8" : "R6", int'(valid_o), 0);
    if (poke) chk(mode_err_o === 1'b0, "R10", int'(mode_err_o), 0);
  endtask

  task automatic bad_start(input logic [2:0] code, input bit il);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h5a; len_code_i = code; ilv_i = il;
    @(negedge clk);
    start_i = 1'b0;
    chk(mode_err_o === 1'b1 && valid_o === 1'b0, "R9", int'({mode_err_o, valid_o}), 2);
    @(negedge clk);
    chk(mode_err_o === 1'b0 && valid_o === 1'b0, "R9", int'({mode_err_o, valid_o}), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] codes [4];
    codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b011; codes[3] = 3'b111;
    void'($urandom(32'd1234));
    #5;
    chk(valid_o === 1'b0 && last_o === 1'b0 && mode_err_o === 1'b0 && col_o === 8'h00,
        "R1", int'({valid_o, last_o, mode_err_o}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0 && col_o === 8'h00, "R1", int'(col_o), 0);

    // directed orders
    run_burst(5, 3'b011, 1'b0, -1, 1'b0);      // R3 5-6-7-0-1-2-3-4
    run_burst(5, 3'b011, 1'b1, -1, 1'b0);      // R4 5-4-7-6-1-0-3-2
    run_burst(8'hb7, 3'b010, 1'b0, -1, 1'b0);  // R5 upper bits stay
    run_burst(8'hb6, 3'b001, 1'b1, -1, 1'b0);
    run_burst(8'hfd, 3'b111, 1'b0, 300, 1'b0); // R7 wraps past 255
    run_burst(8'h20, 3'b011, 1'b0, 7, 1'b0);   // R8 term on last beat
    run_burst(8'h33, 3'b011, 1'b1, 2, 1'b0);   // R8 early term
    run_burst(8'h42, 3'b010, 1'b1, -1, 1'b1);  // R10 start while busy
    bad_start(3'b000, 1'b0);
    bad_start(3'b100, 1'b1);
    bad_start(3'b101, 1'b0);
    bad_start(3'b110, 1'b0);
    bad_start(3'b111, 1'b1);

    for (int i = 0; i < 60; i++) begin
      int s, c, t;
      bit il;
      s = int'($urandom_range(0, 255));
      c = int'($urandom_range(0, 3));
      il = (c == 3) ? 1'b0 : 1'($urandom_range(0, 1));
      t = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 9)) : -1;
      if (c == 3 && t < 0) t = int'($urandom_range(0, 280));
      run_burst(s, codes[c], il, t, 1'($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule